// File: doc/BRIEF.md
# Prefetch Request Admission Filter

This block stands between a hardware prefetcher's request queue and the controller of a split instruction/data first-level cache. It looks at the request at the head of the queue, which carries a line address and a request kind, and settles that request in one of three ways. It can discard the request because the line is already cached. It can pass a typed prefetch event on to the line state machine so that a fill is requested from the next level. Or, when the target set has no free way, it can ask the controller to evict a victim line. In that last case the request stays at the head of the queue and is decided again once the eviction has been accepted.

The block does not hold the tag arrays. It drives the head address and a target-array select to the lookup logic outside the block. It receives back, in the same cycle, a hit flag for each array, a free-way flag for the target set and the address of the victim that would be evicted. The queue side, the event side and the replacement side are each valid/ready channels. The queue is popped when `req_valid` and `req_ready` are both high at a rising clock edge. An event or replacement transfer completes when its valid and ready are both high at a rising edge. An output valid never drops, and its payload never changes, until that transfer has happened. `req_ready` is low while a replacement is waiting, and it is also low while a forwarded request has no free output slot.

Top module: `pf_admit_filter`

## Requirements
- R1: Request kind codes map to event codes as follows: load (0) gives event 0, instruction fetch (1) gives event 1, and store (2) or atomic (3) gives event 2. Every event carries the supervisor flag `evt_priv` = 1.
- R2: Kind codes 4 to 7 are illegal. Such a request is popped, `err_kind` is high for exactly the one cycle after the pop, and no event or replacement is produced.
- R3: `lkp_instr` is 1 for an instruction-fetch request and 0 for every other kind.
- R4: A line that hits in the target array is popped and produces no event and no replacement.
- R5: A line that hits only in the opposite array is popped and produces no event and no replacement.
- R6: A line that misses both arrays while `tgt_free` is 1 is popped, and the event appears on `evt_valid` in the cycle after the pop with `evt_addr` equal to the request address.
- R7: A line that misses both arrays while `tgt_free` is 0 is not popped. `repl_valid` rises in the next cycle with `repl_addr` equal to `victim_addr` and `repl_instr` equal to the target select.
- R8: While `repl_valid` is high, `req_ready` is low and no new event is issued. The replacement payload stays stable until it is accepted.
- R9: While `evt_valid` is high and `evt_ready` is low, the event payload stays stable and a new request that would be forwarded is not popped. If the slot drains in the same cycle, a new event may be loaded in that cycle.
- R10: Checks are applied in the order target hit, then opposite hit, then free way. At most one outcome occurs per cycle.
- R11: After reset, `evt_valid`, `repl_valid` and `err_kind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Queue head holds a request |
| req_ready | output | 1 | Head request is consumed this cycle |
| req_addr | input | ADDR_W | Line address of the head request |
| req_kind | input | 3 | Request kind code |
| lkp_addr | output | ADDR_W | Address presented to the tag lookups |
| lkp_instr | output | 1 | Target array select: 1 selects the instruction array, 0 the data array |
| i_hit | input | 1 | Line valid in the instruction array |
| d_hit | input | 1 | Line valid in the data array |
| tgt_free | input | 1 | Target set has a free way |
| victim_addr | input | ADDR_W | Probed victim line in the target set |
| evt_valid | output | 1 | Prefetch event pending |
| evt_ready | input | 1 | Controller accepts the event |
| evt_addr | output | ADDR_W | Line address of the event |
| evt_kind | output | 2 | Event code (0 load, 1 ifetch, 2 store) |
| evt_priv | output | 1 | Supervisor access mode flag |
| repl_valid | output | 1 | Replacement request pending |
| repl_ready | input | 1 | Controller accepts the replacement |
| repl_addr | output | ADDR_W | Victim line to evict |
| repl_instr | output | 1 | Array that holds the victim |
| err_kind | output | 1 | One-cycle pulse for an illegal kind |

## Verification
If the decode selects the wrong array, a hit in the correct array goes unnoticed. The request then shows up one cycle later as a spurious event or replacement, while an outcome of "popped and silent" was expected. If the order of the checks is wrong, a request that hits the target but has a full set raises `repl_valid` in the next cycle, and a request that should have been dropped is held in the queue. A stuck output slot is visible in the same cycle as a `req_ready` that stays low, or as a payload that changes under back-pressure. If the replacement hold is broken, `req_ready` goes high before the eviction has been accepted.

// File: rtl/pf_admit_pkg.sv
package pf_admit_pkg;

  localparam int KIND_W = 3;
  localparam int EV_W   = 2;

  // request kind codes
  localparam logic [KIND_W-1:0] RK_LOAD   = 3'd0;
  localparam logic [KIND_W-1:0] RK_IFETCH = 3'd1;
  localparam logic [KIND_W-1:0] RK_STORE  = 3'd2;
  localparam logic [KIND_W-1:0] RK_ATOMIC = 3'd3;

  typedef enum logic [EV_W-1:0] {
    PEV_LOAD   = 2'd0,
    PEV_IFETCH = 2'd1,
    PEV_STORE  = 2'd2,
    PEV_NONE   = 2'd3
  } pf_event_e;

  typedef enum logic [2:0] {
    OC_DROP_BAD = 3'd0,
    OC_DROP_TGT = 3'd1,
    OC_DROP_OPP = 3'd2,
    OC_FWD      = 3'd3,
    OC_REPL     = 3'd4
  } pf_outcome_e;

endpackage

// File: rtl/pf_kind_decode.sv
module pf_kind_decode
  import pf_admit_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output logic              legal,
  output logic              tgt_instr,
  output pf_event_e         ev
);

  always_comb begin
    legal     = 1'b1;
    tgt_instr = 1'b0;
    ev        = PEV_NONE;
    unique case (kind)
      RK_LOAD:   ev = PEV_LOAD;
      RK_IFETCH: begin
        ev        = PEV_IFETCH;
        tgt_instr = 1'b1;
      end
      RK_STORE,
      RK_ATOMIC: ev = PEV_STORE;
      default:   legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/pf_admit_decide.sv
module pf_admit_decide
  import pf_admit_pkg::*;
(
  input  logic        legal,
  input  logic        tgt_instr,
  input  logic        i_hit,
  input  logic        d_hit,
  input  logic        tgt_free,
  output pf_outcome_e outcome
);

  logic hit_tgt;
  logic hit_opp;

  assign hit_tgt = tgt_instr ? i_hit : d_hit;
  assign hit_opp = tgt_instr ? d_hit : i_hit;

  // priority: legality, own array, other array, free way
  always_comb begin
    if (!legal)        outcome = OC_DROP_BAD;
    else if (hit_tgt)  outcome = OC_DROP_TGT;
    else if (hit_opp)  outcome = OC_DROP_OPP;
    else if (tgt_free) outcome = OC_FWD;
    else               outcome = OC_REPL;
  end

endmodule

// File: rtl/pf_out_slot.sv
module pf_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         can_load
);

  assign can_load = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pf_admit_filter.sv
module pf_admit_filter
  import pf_admit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [KIND_W-1:0] req_kind,
  output logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_instr,
  input  logic              i_hit,
  input  logic              d_hit,
  input  logic              tgt_free,
  input  logic [ADDR_W-1:0] victim_addr,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [EV_W-1:0]   evt_kind,
  output logic              evt_priv,
  output logic              repl_valid,
  input  logic              repl_ready,
  output logic [ADDR_W-1:0] repl_addr,
  output logic              repl_instr,
  output logic              err_kind
);

  localparam int EVT_PW  = EV_W + ADDR_W;
  localparam int REPL_PW = 1 + ADDR_W;

  logic        legal;
  logic        tgt_instr;
  pf_event_e   ev;
  pf_outcome_e outcome;

  logic               evt_can_load;
  logic               repl_can_load;
  logic               evt_load;
  logic               repl_load;
  logic               head_free;
  logic               is_drop;
  logic [EVT_PW-1:0]  evt_din;
  logic [EVT_PW-1:0]  evt_dout;
  logic [REPL_PW-1:0] repl_din;
  logic [REPL_PW-1:0] repl_dout;
  logic               err_q;

  pf_kind_decode u_dec (
    .kind      (req_kind),
    .legal     (legal),
    .tgt_instr (tgt_instr),
    .ev        (ev)
  );

  pf_admit_decide u_decide (
    .legal     (legal),
    .tgt_instr (tgt_instr),
    .i_hit     (i_hit),
    .d_hit     (d_hit),
    .tgt_free  (tgt_free),
    .outcome   (outcome)
  );

  assign lkp_addr  = req_addr;
  assign lkp_instr = tgt_instr;

  // lookups are stale while an eviction is outstanding
  assign head_free = !repl_valid;
  assign is_drop   = (outcome == OC_DROP_BAD) || (outcome == OC_DROP_TGT) ||
                     (outcome == OC_DROP_OPP);

  assign req_ready = head_free &&
                     (is_drop || ((outcome == OC_FWD) && evt_can_load));
  assign evt_load  = req_valid && head_free && (outcome == OC_FWD) && evt_can_load;
  assign repl_load = req_valid && head_free && (outcome == OC_REPL) && repl_can_load;

  assign evt_din  = {ev, req_addr};
  assign repl_din = {tgt_instr, victim_addr};

  pf_out_slot #(.W(EVT_PW)) u_evt_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (evt_load),
    .din      (evt_din),
    .ready    (evt_ready),
    .valid    (evt_valid),
    .dout     (evt_dout),
    .can_load (evt_can_load)
  );

  pf_out_slot #(.W(REPL_PW)) u_repl_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (repl_load),
    .din      (repl_din),
    .ready    (repl_ready),
    .valid    (repl_valid),
    .dout     (repl_dout),
    .can_load (repl_can_load)
  );

  assign evt_kind   = evt_dout[EVT_PW-1 -: EV_W];
  assign evt_addr   = evt_dout[ADDR_W-1:0];
  assign evt_priv   = 1'b1;
  assign repl_instr = repl_dout[REPL_PW-1];
  assign repl_addr  = repl_dout[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= req_valid && req_ready && (outcome == OC_DROP_BAD);
  end

  assign err_kind = err_q;

endmodule

// File: rtl/pf_admit_filter_chk.sv
module pf_admit_filter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_kind,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [ADDR_W-1:0] evt_addr,
  input logic [1:0]        evt_kind,
  input logic              repl_valid,
  input logic              repl_ready,
  input logic [ADDR_W-1:0] repl_addr,
  input logic              err_kind
);

  // R1
  evt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_kind != 2'd3));

  // R2
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_kind |-> $past(req_valid && req_ready && (req_kind > 3'd3)));

  // R6
  evt_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> $past(req_valid && req_ready));

  // R7
  repl_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(repl_valid) |-> $past(req_valid && !req_ready));

  // R8
  repl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_valid && !repl_ready) |=> (repl_valid && $stable(repl_addr)));

  // R9
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_addr) && $stable(evt_kind)));

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(evt_valid) && $rose(repl_valid)));

endmodule

bind pf_admit_filter pf_admit_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .evt_valid  (evt_valid),
  .evt_ready  (evt_ready),
  .evt_addr   (evt_addr),
  .evt_kind   (evt_kind),
  .repl_valid (repl_valid),
  .repl_ready (repl_ready),
  .repl_addr  (repl_addr),
  .err_kind   (err_kind)
);

// File: tb/tb_pf_admit_filter.sv
module tb_pf_admit_filter;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [2:0]    req_kind;
  logic [AW-1:0] lkp_addr;
  logic          lkp_instr;
  logic          i_hit, d_hit, tgt_free;
  logic [AW-1:0] victim_addr;
  logic          evt_valid, evt_ready, evt_priv;
  logic [AW-1:0] evt_addr;
  logic [1:0]    evt_kind;
  logic          repl_valid, repl_ready, repl_instr;
  logic [AW-1:0] repl_addr;
  logic          err_kind;

  pf_admit_filter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind),
    .lkp_addr(lkp_addr), .lkp_instr(lkp_instr),
    .i_hit(i_hit), .d_hit(d_hit), .tgt_free(tgt_free),
    .victim_addr(victim_addr),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_addr(evt_addr), .evt_kind(evt_kind), .evt_priv(evt_priv),
    .repl_valid(repl_valid), .repl_ready(repl_ready),
    .repl_addr(repl_addr), .repl_instr(repl_instr),
    .err_kind(err_kind)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic present(logic [AW-1:0] a, logic [2:0] k, logic ih, logic dh,
                         logic fr, logic [AW-1:0] v);
    req_valid   = 1'b1;
    req_addr    = a;
    req_kind    = k;
    i_hit       = ih;
    d_hit       = dh;
    tgt_free    = fr;
    victim_addr = v;
    #1;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    tick();
  endtask

  // R11
  task automatic t_reset();
    chk("R11 evt_valid", evt_valid, 0);
    chk("R11 repl_valid", repl_valid, 0);
    chk("R11 err_kind", err_kind, 0);
  endtask

  // R1 R3 R6
  task automatic t_forward_kinds();
    evt_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] a;
      a = 32'h1000 + k * 32'h40;
      present(a, 3'(k), 1'b0, 1'b0, 1'b1, 32'h0);
      chk("R3 lkp_instr", lkp_instr, (k == 1) ? 1 : 0);
      chk("R6 req_ready", req_ready, 1);
      tick();
      req_valid = 1'b0;
      chk("R6 evt_valid", evt_valid, 1);
      chk("R6 evt_addr", evt_addr, a);
      chk("R1 evt_kind", evt_kind, (k == 3) ? 2 : k);
      chk("R1 evt_priv", evt_priv, 1);
      tick();
      chk("R6 evt drained", evt_valid, 0);
    end
  endtask

  // R2
  task automatic t_illegal();
    for (int k = 4; k < 8; k++) begin
      present(32'h2000, 3'(k), 1'b0, 1'b0, 1'b0, 32'h9000);
      chk("R2 req_ready", req_ready, 1);
      tick();
      req_valid = 1'b0;
      chk("R2 err_kind", err_kind, 1);
      chk("R2 evt_valid", evt_valid, 0);
      chk("R2 repl_valid", repl_valid, 0);
      tick();
      chk("R2 err pulse", err_kind, 0);
    end
  endtask

  // R4 R10
  task automatic t_target_hit();
    present(32'h3000, 3'd0, 1'b1, 1'b1, 1'b0, 32'h9000);
    chk("R10 full set but hit popped", req_ready, 1);
    tick();
    req_valid = 1'b0;
    chk("R4 no evt", evt_valid, 0);
    chk("R10 no repl", repl_valid, 0);
    present(32'h3040, 3'd1, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R4 ifetch req_ready", req_ready, 1);
    tick();
    req_valid = 1'b0;
    chk("R4 ifetch no evt", evt_valid, 0);
  endtask

  // R5
  task automatic t_opposite_hit();
    present(32'h4000, 3'd2, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R5 store opp req_ready", req_ready, 1);
    tick();
    req_valid = 1'b0;
    chk("R5 store no evt", evt_valid, 0);
    present(32'h4040, 3'd1, 1'b0, 1'b1, 1'b0, 32'h9000);
    chk("R5 ifetch opp req_ready", req_ready, 1);
    tick();
    req_valid = 1'b0;
    chk("R5 ifetch no evt", evt_valid, 0);
    chk("R5 ifetch no repl", repl_valid, 0);
  endtask

  // R7 R8
  task automatic t_replace();
    repl_ready = 1'b0;
    evt_ready  = 1'b1;
    present(32'h5000, 3'd1, 1'b0, 1'b0, 1'b0, 32'h7FC0);
    chk("R7 not popped", req_ready, 0);
    tick();
    chk("R7 repl_valid", repl_valid, 1);
    chk("R7 repl_addr", repl_addr, 32'h7FC0);
    chk("R7 repl_instr", repl_instr, 1);
    chk("R7 no evt", evt_valid, 0);
    tgt_free = 1'b1;
    #1;
    chk("R8 held while pending", req_ready, 0);
    tick();
    chk("R8 repl still valid", repl_valid, 1);
    chk("R8 no evt while pending", evt_valid, 0);
    repl_ready = 1'b1;
    #1;
    chk("R8 held in accept cycle", req_ready, 0);
    tick();
    repl_ready = 1'b0;
    chk("R8 repl accepted", repl_valid, 0);
    chk("R8 head released", req_ready, 1);
    tick();
    req_valid = 1'b0;
    chk("R7 retry forwards", evt_valid, 1);
    chk("R7 retry kind", evt_kind, 1);
    chk("R7 retry addr", evt_addr, 32'h5000);
    tick();
  endtask

  // R9
  task automatic t_backpressure();
    evt_ready = 1'b0;
    present(32'h6000, 3'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    tick();
    chk("R9 first evt", evt_addr, 32'h6000);
    present(32'h6040, 3'd3, 1'b0, 1'b0, 1'b1, 32'h0);
    chk("R9 slot full blocks", req_ready, 0);
    tick();
    chk("R9 evt held", evt_valid, 1);
    chk("R9 addr stable", evt_addr, 32'h6000);
    chk("R9 kind stable", evt_kind, 0);
    evt_ready = 1'b1;
    #1;
    chk("R9 drain same cycle", req_ready, 1);
    tick();
    req_valid = 1'b0;
    chk("R9 second evt", evt_addr, 32'h6040);
    chk("R9 second kind", evt_kind, 2);
    tick();
    chk("R9 drained", evt_valid, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_kind = '0;
    i_hit = 1'b0; d_hit = 1'b0; tgt_free = 1'b0; victim_addr = '0;
    evt_ready = 1'b0; repl_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    idle();
    t_forward_kinds();
    t_illegal();
    t_target_hit();
    t_opposite_hit();
    t_replace();
    t_backpressure();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule